// File: doc/BRIEF.md
# Display Mode-Line Legalizer

This block takes a requested display mode line and returns one that a timing generator can hold. The mode line has four horizontal values (end of active display, start of sync, end of sync, total) and the same four vertical values. The block applies a fixed sequence of clamping rules. The rules make the line fit the register fields, keep the active area within sensible bounds, leave room for blanking and place a sync pulse of legal length inside the blanking interval.

Each rule works on values that earlier rules may already have changed, so the order of the rules is part of the behaviour. A request is accepted on a valid/ready handshake. The block then spends one clock cycle on each rule group and presents the registered result on a second valid/ready handshake. All values are 16-bit unsigned. Every addition saturates and every subtraction stops at zero.

Top module: `modeline_clamp`

## Requirements
- R1: On acceptance, the three low bits of every horizontal input are cleared, so each horizontal output is a multiple of 8. Vertical inputs are not rounded.
- R2: Caps from the field width are applied before any other clamp. The horizontal caps are 4072 for display end, 4080 for sync start, 4088 for sync end and 4128 for total. The vertical caps are 2045 for display end, 2046 for sync start, 2047 for sync end and 2049 for total.
- R3: After the width caps, horizontal display end is forced into 640..2048 and vertical display end is forced into 480..1536.
- R4: Horizontal total is first raised to at least display end + 80. It is then lowered to at most display end + 1016.
- R5: Horizontal sync end is capped at total − 8. Horizontal sync start is raised to at least display end + 8.
- R6: After R5, horizontal sync end is capped at sync start + 248.
- R7: Vertical total is first raised to at least display end + 3. It is then lowered to at most display end + 255.
- R8: Vertical sync end is capped at total − 1, and vertical sync start is raised to at least display end + 1. After that, vertical sync end is capped at sync start + 15.
- R9: inReady is high only when the block is idle and drops after an accepted request. outValid first goes high six clock edges after the accepting edge. After the result is taken with outValid and outReady high, inReady returns.
- R10: While outValid is high and outReady is low, outValid stays high and all eight outputs hold their values.
- R11: During and right after reset, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block can accept a request |
| hDispEndIn | input | 16 | Requested horizontal display end |
| hSyncStartIn | input | 16 | Requested horizontal sync start |
| hSyncEndIn | input | 16 | Requested horizontal sync end |
| hTotalIn | input | 16 | Requested horizontal total |
| vDispEndIn | input | 16 | Requested vertical display end |
| vSyncStartIn | input | 16 | Requested vertical sync start |
| vSyncEndIn | input | 16 | Requested vertical sync end |
| vTotalIn | input | 16 | Requested vertical total |
| outValid | output | 1 | Legal mode line present |
| outReady | input | 1 | Consumer takes the result |
| hDispEndOut | output | 16 | Legal horizontal display end |
| hSyncStartOut | output | 16 | Legal horizontal sync start |
| hSyncEndOut | output | 16 | Legal horizontal sync end |
| hTotalOut | output | 16 | Legal horizontal total |
| vDispEndOut | output | 16 | Legal vertical display end |
| vSyncStartOut | output | 16 | Legal vertical sync start |
| vSyncEndOut | output | 16 | Legal vertical sync end |
| vTotalOut | output | 16 | Legal vertical total |

## Verification
The assertions assume that the consumer obeys the handshake. They also assume that request fields are only sampled on the accepting edge, so changing the inputs while the block is busy must not affect the result. The stimulus changes inputs only at falling edges and drops inValid right after acceptance. It drives outReady either always high or with a stall pattern, so that held results are observed over several cycles. The request vectors cover unchanged legal lines, unaligned values, all-ones and all-zero values, oversized totals and overlong sync pulses. These push every clamp to its limit.

// File: rtl/modeline_pkg.sv
package modeline_pkg;

  // Rule groups, applied one per cycle in this order after the load.
  typedef enum logic [2:0] {
    STEP_NONE     = 3'd0,
    STEP_WIDTH    = 3'd1,
    STEP_RANGE    = 3'd2,
    STEP_TOT_UP   = 3'd3,
    STEP_TOT_DN   = 3'd4,
    STEP_SYNC_POS = 3'd5,
    STEP_SYNC_LEN = 3'd6
  } step_e;

  localparam int NUM_STEPS = 6;
  localparam int STEP_W    = $bits(step_e);

  // Strobes from control to datapath.
  typedef struct packed {
    logic  load;
    step_e step;
  } clampCtl_t;

endpackage

// File: rtl/mlc_ctrl.sv
module mlc_ctrl
  import modeline_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output logic      inReady,
  output logic      outValid,
  input  logic      outReady,
  output clampCtl_t ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e            state;
  logic [STEP_W-1:0] stepCnt;

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_DONE);

  always_comb begin
    ctl.load = inValid && inReady;
    ctl.step = (state == ST_RUN) ? step_e'(stepCnt) : STEP_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (inValid) begin
            state   <= ST_RUN;
            stepCnt <= STEP_W'(1);
          end
        end
        ST_RUN: begin
          if (stepCnt == STEP_W'(NUM_STEPS)) begin
            state   <= ST_DONE;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + STEP_W'(1);
          end
        end
        ST_DONE: begin
          if (outReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mlc_axis.sv
module mlc_axis
  import modeline_pkg::*;
#(
  parameter int W            = 16,
  parameter int GB           = 3,     // granularity bits (rounding)
  parameter int FIELD_MAX    = 511,
  parameter int OFF_DE       = -2,
  parameter int OFF_SS       = -1,
  parameter int OFF_SE       = 0,
  parameter int OFF_TOT      = 5,
  parameter int DISP_MIN     = 640,
  parameter int DISP_MAX     = 2048,
  parameter int TOT_ROOM     = 80,
  parameter int BLANK_MAX    = 1016,
  parameter int SYNC_LEN_MAX = 248
) (
  input  logic          clk,
  input  logic          rstN,
  input  clampCtl_t     ctl,
  input  logic [W-1:0]  reqDe,
  input  logic [W-1:0]  reqSs,
  input  logic [W-1:0]  reqSe,
  input  logic [W-1:0]  reqTot,
  output logic [W-1:0]  de,
  output logic [W-1:0]  ss,
  output logic [W-1:0]  se,
  output logic [W-1:0]  tot
);

  typedef logic [W-1:0] val_t;

  localparam val_t GAP     = val_t'(1 << GB);
  localparam val_t KEEP    = ~val_t'((1 << GB) - 1);
  localparam val_t CAP_DE  = val_t'((FIELD_MAX + OFF_DE)  << GB);
  localparam val_t CAP_SS  = val_t'((FIELD_MAX + OFF_SS)  << GB);
  localparam val_t CAP_SE  = val_t'((FIELD_MAX + OFF_SE)  << GB);
  localparam val_t CAP_TOT = val_t'((FIELD_MAX + OFF_TOT) << GB);
  localparam val_t D_MIN   = val_t'(DISP_MIN);
  localparam val_t D_MAX   = val_t'(DISP_MAX);
  localparam val_t ROOM    = val_t'(TOT_ROOM);
  localparam val_t BLANK   = val_t'(BLANK_MAX);
  localparam val_t SLEN    = val_t'(SYNC_LEN_MAX);

  function automatic val_t satAdd(input val_t a, input val_t b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W] ? '1 : s[W-1:0];
  endfunction

  function automatic val_t satSub(input val_t a, input val_t b);
    return (a > b) ? (a - b) : '0;
  endfunction

  function automatic val_t umin(input val_t a, input val_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic val_t umax(input val_t a, input val_t b);
    return (a > b) ? a : b;
  endfunction

  val_t nDe, nSs, nSe, nTot;

  always_comb begin
    nDe  = de;
    nSs  = ss;
    nSe  = se;
    nTot = tot;
    case (ctl.step)
      STEP_WIDTH: begin
        nDe  = umin(de,  CAP_DE);
        nSs  = umin(ss,  CAP_SS);
        nSe  = umin(se,  CAP_SE);
        nTot = umin(tot, CAP_TOT);
      end
      STEP_RANGE:    nDe  = umin(umax(de, D_MIN), D_MAX);
      STEP_TOT_UP:   nTot = umax(tot, satAdd(de, ROOM));
      STEP_TOT_DN:   nTot = umin(tot, satAdd(de, BLANK));
      STEP_SYNC_POS: begin
        nSe = umin(se, satSub(tot, GAP));
        nSs = umax(ss, satAdd(de, GAP));
      end
      STEP_SYNC_LEN: nSe = umin(se, satAdd(ss, SLEN));
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      de  <= '0;
      ss  <= '0;
      se  <= '0;
      tot <= '0;
    end else if (ctl.load) begin
      de  <= reqDe  & KEEP;
      ss  <= reqSs  & KEEP;
      se  <= reqSe  & KEEP;
      tot <= reqTot & KEEP;
    end else begin
      de  <= nDe;
      ss  <= nSs;
      se  <= nSe;
      tot <= nTot;
    end
  end

endmodule

// File: rtl/mlc_datapath.sv
module mlc_datapath
  import modeline_pkg::*;
#(
  parameter int VAL_W          = 16,
  parameter int H_GRAN_BITS    = 3,
  parameter int H_FIELD_MAX    = 511,
  parameter int V_FIELD_MAX    = 2047,
  parameter int H_DISP_MIN     = 640,
  parameter int H_DISP_MAX     = 2048,
  parameter int V_DISP_MIN     = 480,
  parameter int V_DISP_MAX     = 1536,
  parameter int H_TOT_ROOM     = 80,
  parameter int V_TOT_ROOM     = 3,
  parameter int H_BLANK_MAX    = 1016,
  parameter int V_BLANK_MAX    = 255,
  parameter int H_SYNC_LEN_MAX = 248,
  parameter int V_SYNC_LEN_MAX = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  clampCtl_t        ctl,
  input  logic [VAL_W-1:0] hReq [4],
  input  logic [VAL_W-1:0] vReq [4],
  output logic [VAL_W-1:0] hOut [4],
  output logic [VAL_W-1:0] vOut [4]
);

  // Index order of each group: display end, sync start, sync end, total.
  mlc_axis #(
    .W(VAL_W), .GB(H_GRAN_BITS), .FIELD_MAX(H_FIELD_MAX),
    .OFF_DE(-2), .OFF_SS(-1), .OFF_SE(0), .OFF_TOT(5),
    .DISP_MIN(H_DISP_MIN), .DISP_MAX(H_DISP_MAX), .TOT_ROOM(H_TOT_ROOM),
    .BLANK_MAX(H_BLANK_MAX), .SYNC_LEN_MAX(H_SYNC_LEN_MAX)
  ) uHoriz (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqDe(hReq[0]), .reqSs(hReq[1]), .reqSe(hReq[2]), .reqTot(hReq[3]),
    .de(hOut[0]), .ss(hOut[1]), .se(hOut[2]), .tot(hOut[3])
  );

  mlc_axis #(
    .W(VAL_W), .GB(0), .FIELD_MAX(V_FIELD_MAX),
    .OFF_DE(-2), .OFF_SS(-1), .OFF_SE(0), .OFF_TOT(2),
    .DISP_MIN(V_DISP_MIN), .DISP_MAX(V_DISP_MAX), .TOT_ROOM(V_TOT_ROOM),
    .BLANK_MAX(V_BLANK_MAX), .SYNC_LEN_MAX(V_SYNC_LEN_MAX)
  ) uVert (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqDe(vReq[0]), .reqSs(vReq[1]), .reqSe(vReq[2]), .reqTot(vReq[3]),
    .de(vOut[0]), .ss(vOut[1]), .se(vOut[2]), .tot(vOut[3])
  );

endmodule

// File: rtl/modeline_clamp.sv
module modeline_clamp
  import modeline_pkg::*;
#(
  parameter int VAL_W          = 16,
  parameter int H_GRAN_BITS    = 3,
  parameter int H_FIELD_MAX    = 511,
  parameter int V_FIELD_MAX    = 2047,
  parameter int H_DISP_MIN     = 640,
  parameter int H_DISP_MAX     = 2048,
  parameter int V_DISP_MIN     = 480,
  parameter int V_DISP_MAX     = 1536,
  parameter int H_TOT_ROOM     = 80,
  parameter int V_TOT_ROOM     = 3,
  parameter int H_BLANK_MAX    = 1016,
  parameter int V_BLANK_MAX    = 255,
  parameter int H_SYNC_LEN_MAX = 248,
  parameter int V_SYNC_LEN_MAX = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [VAL_W-1:0] hDispEndIn,
  input  logic [VAL_W-1:0] hSyncStartIn,
  input  logic [VAL_W-1:0] hSyncEndIn,
  input  logic [VAL_W-1:0] hTotalIn,
  input  logic [VAL_W-1:0] vDispEndIn,
  input  logic [VAL_W-1:0] vSyncStartIn,
  input  logic [VAL_W-1:0] vSyncEndIn,
  input  logic [VAL_W-1:0] vTotalIn,
  output logic             outValid,
  input  logic             outReady,
  output logic [VAL_W-1:0] hDispEndOut,
  output logic [VAL_W-1:0] hSyncStartOut,
  output logic [VAL_W-1:0] hSyncEndOut,
  output logic [VAL_W-1:0] hTotalOut,
  output logic [VAL_W-1:0] vDispEndOut,
  output logic [VAL_W-1:0] vSyncStartOut,
  output logic [VAL_W-1:0] vSyncEndOut,
  output logic [VAL_W-1:0] vTotalOut
);

  clampCtl_t        ctl;
  logic [VAL_W-1:0] hReq [4];
  logic [VAL_W-1:0] vReq [4];
  logic [VAL_W-1:0] hOut [4];
  logic [VAL_W-1:0] vOut [4];

  assign hReq[0] = hDispEndIn;
  assign hReq[1] = hSyncStartIn;
  assign hReq[2] = hSyncEndIn;
  assign hReq[3] = hTotalIn;
  assign vReq[0] = vDispEndIn;
  assign vReq[1] = vSyncStartIn;
  assign vReq[2] = vSyncEndIn;
  assign vReq[3] = vTotalIn;

  assign hDispEndOut   = hOut[0];
  assign hSyncStartOut = hOut[1];
  assign hSyncEndOut   = hOut[2];
  assign hTotalOut     = hOut[3];
  assign vDispEndOut   = vOut[0];
  assign vSyncStartOut = vOut[1];
  assign vSyncEndOut   = vOut[2];
  assign vTotalOut     = vOut[3];

  mlc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .ctl(ctl)
  );

  mlc_datapath #(
    .VAL_W(VAL_W), .H_GRAN_BITS(H_GRAN_BITS), .H_FIELD_MAX(H_FIELD_MAX),
    .V_FIELD_MAX(V_FIELD_MAX), .H_DISP_MIN(H_DISP_MIN), .H_DISP_MAX(H_DISP_MAX),
    .V_DISP_MIN(V_DISP_MIN), .V_DISP_MAX(V_DISP_MAX), .H_TOT_ROOM(H_TOT_ROOM),
    .V_TOT_ROOM(V_TOT_ROOM), .H_BLANK_MAX(H_BLANK_MAX), .V_BLANK_MAX(V_BLANK_MAX),
    .H_SYNC_LEN_MAX(H_SYNC_LEN_MAX), .V_SYNC_LEN_MAX(V_SYNC_LEN_MAX)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hReq(hReq), .vReq(vReq), .hOut(hOut), .vOut(vOut)
  );

endmodule

// File: rtl/mlc_checker.sv
module mlc_checker
  import modeline_pkg::*;
#(
  parameter int VAL_W          = 16,
  parameter int H_DISP_MIN     = 640,
  parameter int H_DISP_MAX     = 2048,
  parameter int V_DISP_MIN     = 480,
  parameter int V_DISP_MAX     = 1536,
  parameter int H_TOT_ROOM     = 80,
  parameter int V_TOT_ROOM     = 3,
  parameter int H_BLANK_MAX    = 1016,
  parameter int V_BLANK_MAX    = 255,
  parameter int H_SYNC_LEN_MAX = 248,
  parameter int V_SYNC_LEN_MAX = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [VAL_W-1:0] hDispEndOut,
  input logic [VAL_W-1:0] hSyncStartOut,
  input logic [VAL_W-1:0] hSyncEndOut,
  input logic [VAL_W-1:0] hTotalOut,
  input logic [VAL_W-1:0] vDispEndOut,
  input logic [VAL_W-1:0] vSyncStartOut,
  input logic [VAL_W-1:0] vSyncEndOut,
  input logic [VAL_W-1:0] vTotalOut
);

  localparam int CNT_W = $clog2(NUM_STEPS + 3);

  logic [CNT_W-1:0] sinceAccept;

  always_ff @(posedge clk) begin
    if (!rstN) sinceAccept <= '0;
    else if (inValid && inReady) sinceAccept <= CNT_W'(1);
    else if (sinceAccept != '0 && sinceAccept != CNT_W'(NUM_STEPS + 2))
      sinceAccept <= sinceAccept + CNT_W'(1);
  end

  assert_reset_state_R11: assert property (@(posedge clk)
    !rstN |=> !outValid && inReady);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> sinceAccept == CNT_W'(NUM_STEPS + 1));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable({hDispEndOut, hSyncStartOut,
      hSyncEndOut, hTotalOut, vDispEndOut, vSyncStartOut, vSyncEndOut, vTotalOut}));

  assert_h_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (hDispEndOut[2:0] == 3'd0) && (hSyncStartOut[2:0] == 3'd0)
              && (hSyncEndOut[2:0] == 3'd0) && (hTotalOut[2:0] == 3'd0));

  assert_disp_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> 32'(hDispEndOut) >= H_DISP_MIN && 32'(hDispEndOut) <= H_DISP_MAX
              && 32'(vDispEndOut) >= V_DISP_MIN && 32'(vDispEndOut) <= V_DISP_MAX);

  assert_h_total_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> 32'(hTotalOut) >= 32'(hDispEndOut) + H_TOT_ROOM
              && 32'(hTotalOut) <= 32'(hDispEndOut) + H_BLANK_MAX);

  assert_h_sync_pos_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> 32'(hSyncStartOut) >= 32'(hDispEndOut) + 8
              && 32'(hSyncEndOut) + 8 <= 32'(hTotalOut));

  assert_h_sync_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> 32'(hSyncEndOut) <= 32'(hSyncStartOut) + H_SYNC_LEN_MAX);

  assert_v_total_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> 32'(vTotalOut) >= 32'(vDispEndOut) + V_TOT_ROOM
              && 32'(vTotalOut) <= 32'(vDispEndOut) + V_BLANK_MAX);

  assert_v_sync_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> 32'(vSyncStartOut) >= 32'(vDispEndOut) + 1
              && 32'(vSyncEndOut) + 1 <= 32'(vTotalOut)
              && 32'(vSyncEndOut) <= 32'(vSyncStartOut) + V_SYNC_LEN_MAX);

endmodule

bind modeline_clamp mlc_checker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady),
  .hDispEndOut(hDispEndOut), .hSyncStartOut(hSyncStartOut),
  .hSyncEndOut(hSyncEndOut), .hTotalOut(hTotalOut),
  .vDispEndOut(vDispEndOut), .vSyncStartOut(vSyncStartOut),
  .vSyncEndOut(vSyncEndOut), .vTotalOut(vTotalOut)
);

// File: tb/sim_modeline_clamp.sv
module sim_modeline_clamp;

  localparam int LATENCY = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rstN, inValid, inReady, outValid, outReady;
  logic [15:0] inW [8];
  logic [15:0] outW [8];

  typedef struct packed {
    logic [7:0][15:0] exp;
    logic [31:0]      acc;
  } item_t;

  item_t sbq[$];
  int    checks = 0, errors = 0, sent = 0, recvd = 0, cyc = 0;
  bit    stallMode = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  modeline_clamp u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .hDispEndIn(inW[0]), .hSyncStartIn(inW[1]), .hSyncEndIn(inW[2]), .hTotalIn(inW[3]),
    .vDispEndIn(inW[4]), .vSyncStartIn(inW[5]), .vSyncEndIn(inW[6]), .vTotalIn(inW[7]),
    .outValid(outValid), .outReady(outReady),
    .hDispEndOut(outW[0]), .hSyncStartOut(outW[1]), .hSyncEndOut(outW[2]), .hTotalOut(outW[3]),
    .vDispEndOut(outW[4]), .vSyncStartOut(outW[5]), .vSyncEndOut(outW[6]), .vTotalOut(outW[7])
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int mn(input int a, input int b); return (a < b) ? a : b; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

  // Expected result built from the requirements, rule by rule.
  function automatic logic [7:0][15:0] refModel(input logic [7:0][15:0] r);
    int hd, hs, he, ht, vd, vs, ve, vt;
    logic [7:0][15:0] o;
    hd = int'(r[0]) & ~7; hs = int'(r[1]) & ~7;                 // R1
    he = int'(r[2]) & ~7; ht = int'(r[3]) & ~7;
    vd = int'(r[4]); vs = int'(r[5]); ve = int'(r[6]); vt = int'(r[7]);
    hd = mn(hd, 4072); hs = mn(hs, 4080); he = mn(he, 4088); ht = mn(ht, 4128); // R2
    vd = mn(vd, 2045); vs = mn(vs, 2046); ve = mn(ve, 2047); vt = mn(vt, 2049);
    hd = mn(mx(hd, 640), 2048); vd = mn(mx(vd, 480), 1536);      // R3
    ht = mx(ht, hd + 80); ht = mn(ht, hd + 1016);                 // R4
    he = mn(he, ht - 8); hs = mx(hs, hd + 8);                     // R5
    he = mn(he, hs + 248);                                        // R6
    vt = mx(vt, vd + 3); vt = mn(vt, vd + 255);                   // R7
    ve = mn(ve, vt - 1); vs = mx(vs, vd + 1); ve = mn(ve, vs + 15); // R8
    o[0] = 16'(hd); o[1] = 16'(hs); o[2] = 16'(he); o[3] = 16'(ht);
    o[4] = 16'(vd); o[5] = 16'(vs); o[6] = 16'(ve); o[7] = 16'(vt);
    return o;
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic sendReq(input int a0, input int a1, input int a2, input int a3,
                         input int b0, input int b1, input int b2, input int b3);
    logic [7:0][15:0] r;
    item_t it;
    r[0] = 16'(a0); r[1] = 16'(a1); r[2] = 16'(a2); r[3] = 16'(a3);
    r[4] = 16'(b0); r[5] = 16'(b1); r[6] = 16'(b2); r[7] = 16'(b3);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    for (int i = 0; i < 8; i++) inW[i] = r[i];
    inValid = 1'b1;
    it.exp = refModel(r);
    it.acc = 32'(cyc + 1);
    sbq.push_back(it);
    sent++;
    @(negedge clk);
    inValid = 1'b0;
    for (int i = 0; i < 8; i++) inW[i] = 16'hA5A5;  // busy-time noise
    check(inReady == 1'b0, "R9", "inReady after accept", inReady, 0);
  endtask

  // Monitor: drives outReady and compares results against the queue.
  initial begin
    bit               seen;
    int               rdyCnt;
    logic [7:0][15:0] snap;
    item_t            cur;
    string            tags [8];
    seen = 1'b0; rdyCnt = 0; outReady = 1'b0; snap = '0; cur = '0;
    tags[0] = "R1/R2/R3 hDispEnd"; tags[1] = "R5 hSyncStart";
    tags[2] = "R6 hSyncEnd";       tags[3] = "R4 hTotal";
    tags[4] = "R2/R3 vDispEnd";    tags[5] = "R8 vSyncStart";
    tags[6] = "R8 vSyncEnd";       tags[7] = "R7 vTotal";
    forever begin
      @(negedge clk);
      rdyCnt++;
      outReady = !stallMode || (rdyCnt % 4 == 3);
      if (rstN && outValid) begin
        if (!seen) begin
          if (sbq.size() == 0) begin
            check(1'b0, "R9", "result without request", 1, 0);
          end else begin
            cur = sbq[0];
            check(cyc == int'(cur.acc) + LATENCY, "R9", "result latency",
                  cyc - int'(cur.acc), LATENCY);
            for (int i = 0; i < 8; i++)
              check(outW[i] == cur.exp[i], tags[i], "value", outW[i], cur.exp[i]);
            for (int i = 0; i < 8; i++) snap[i] = outW[i];
            seen = 1'b1;
          end
        end else begin
          for (int i = 0; i < 8; i++)
            check(outW[i] == snap[i], "R10", "held value", outW[i], snap[i]);
        end
        if (outReady && seen) begin
          void'(sbq.pop_front());
          recvd++;
          seen = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", "run did not complete", cyc, 0);
    finishRun();
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0;
    for (int i = 0; i < 8; i++) inW[i] = '0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R11", "outValid in reset", outValid, 0);
    check(inReady == 1'b1, "R11", "inReady in reset", inReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R11", "outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R11", "inReady after reset", inReady, 1);

    // Legal line passes unchanged; unaligned horizontal values round (R1).
    sendReq(1024, 1048, 1184, 1344, 768, 771, 777, 806);
    sendReq(1027, 1053, 1190, 1350, 770, 772, 780, 810);
    // All ones: field caps then range and blanking limits (R2, R3, R4, R7).
    sendReq(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    // All zero: minimum widths and room for sync (R3, R5, R8).
    sendReq(0, 0, 0, 0, 0, 0, 0, 0);

    stallMode = 1'b1;   // R10 holds across stalls
    sendReq(800, 840, 960, 4000, 600, 601, 604, 2000);
    sendReq(1280, 1100, 2000, 1700, 1024, 800, 900, 1066);
    sendReq(4000, 4050, 4070, 4100, 300, 100, 200, 350);
    sendReq(640, 700, 710, 700, 480, 482, 500, 490);

    while (sbq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(recvd == sent, "R9", "results delivered", recvd, sent);
    check(inReady == 1'b1, "R9", "inReady after last result", inReady, 1);
    finishRun();
  end

endmodule